// File: doc/BRIEF.md
# Pushbutton Input Port with Release Capture

This block presents a bank of pushbuttons to a processor as three registers on a simple 32-bit register bus. The buttons are active-low. Each raw line first passes through a clock-domain synchroniser. The synchronised levels are then exposed in three ways:

- a live register that shows which buttons are currently held down;
- a per-button enable register that software reads and writes;
- a sticky capture register that records each completed press-and-release.

A captured event stays recorded until software clears it. Software clears a capture bit by writing a 1 to that bit, so writing back the value just read clears exactly what was seen. The interrupt output is high while any captured button also has its enable bit set.

The bus is single-cycle. A write is sampled on the rising clock edge while the write strobe is high. Read data follows the byte offset combinationally.

Top module: `btn_port`

## Requirements
- R1: After reset, the live, enable and capture registers all read zero and irq_o is low.
- R2: Offset 0x0 returns the held-down state: bit i is 1 while btn_ni[i] is low. Bit i of every register belongs to button i. A change on btn_ni becomes visible after exactly SYNC_STAGES rising clock edges.
- R3: Offset 0x8 is the enable register. A write stores wdata_i[NUM_BTN-1:0], and a read returns the stored value with all upper bits zero.
- R4: Capture bit i at offset 0xC becomes 1 one edge after the synchronised line of button i goes from low to high, that is, on release. Pressing a button alone sets no capture bit.
- R5: A capture bit stays 1, even across later presses, until software clears it.
- R6: A write to offset 0xC clears each capture bit whose written bit is 1. Capture bits written with 0 are unchanged.
- R7: If a release event and a clear of the same bit occur at the same edge, the bit ends up 1.
- R8: irq_o is high exactly when some button has both its capture bit and its enable bit at 1. Capture happens regardless of the enable bit.
- R9: Reads of any offset other than 0x0, 0x8 and 0xC return zero. Writes to offset 0x0 or to unused offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_ni | input | NUM_BTN | Raw pushbutton lines, low while pressed |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| addr_i | input | 4 | Register byte offset |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the port with its defaults: four buttons, a two-stage synchroniser and 32-bit data. With two stages, the live-register latency can be checked edge by edge, and the release-to-capture edge is known exactly. The bench uses that known edge to line up a clear write with a release event and confirm that the set wins. With four buttons, one-hot and mixed clear patterns, partial enable masks and the zero upper bits of every register all come within reach.

// File: rtl/btn_port_pkg.sv
package btn_port_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] OFS_LIVE = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_EN   = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_CAP  = 4'hC;
endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int NUM_BTN     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_BTN-1:0] raw_i,
  output logic [NUM_BTN-1:0] lvl_o
);
  logic [NUM_BTN-1:0] stg_q [SYNC_STAGES];

  // reset to released level so no false release follows reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SYNC_STAGES; s++) stg_q[s] <= '1;
    end else begin
      stg_q[0] <= raw_i;
      for (int s = 1; s < SYNC_STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign lvl_o = stg_q[SYNC_STAGES-1];
endmodule

// File: rtl/btn_edge_cap.sv
module btn_edge_cap #(
  parameter int NUM_BTN = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_BTN-1:0] lvl_i,
  input  logic [NUM_BTN-1:0] clr_i,
  output logic [NUM_BTN-1:0] cap_o
);
  logic [NUM_BTN-1:0] prev_q, rise, cap_q;

  assign rise = lvl_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '1;
      cap_q  <= '0;
    end else begin
      prev_q <= lvl_i;
      cap_q  <= (cap_q & ~clr_i) | rise;  // set wins over clear
    end
  end

  assign cap_o = cap_q;

  for (genvar i = 0; i < NUM_BTN; i++) begin : g_chk
    // R5
    cap_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cap_q[i] && !clr_i[i] |=> cap_q[i]);
    // R7
    set_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise[i] |=> cap_q[i]);
    // R4
    no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cap_q[i] && !rise[i] |=> !cap_q[i]);
  end
endmodule

// File: rtl/btn_port.sv
module btn_port
  import btn_port_pkg::*;
#(
  parameter int NUM_BTN     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_BTN-1:0] btn_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [NUM_BTN-1:0] lvl, cap, en_q, clr;
  logic               wr_en_reg;

  btn_sync #(.NUM_BTN(NUM_BTN), .SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(btn_ni), .lvl_o(lvl)
  );

  assign wr_en_reg = wr_en_i && (addr_i == OFS_EN);
  assign clr       = (wr_en_i && (addr_i == OFS_CAP)) ? wdata_i[NUM_BTN-1:0] : '0;

  btn_edge_cap #(.NUM_BTN(NUM_BTN)) i_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl), .clr_i(clr), .cap_o(cap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        en_q <= '0;
    else if (wr_en_reg) en_q <= wdata_i[NUM_BTN-1:0];
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_LIVE: rdata_o[NUM_BTN-1:0] = ~lvl;
      OFS_EN:   rdata_o[NUM_BTN-1:0] = en_q;
      OFS_CAP:  rdata_o[NUM_BTN-1:0] = cap;
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o = |(cap & en_q);

  // R3
  en_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_reg |=> en_q == $past(wdata_i[NUM_BTN-1:0]));
  // R8
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !wr_en_i |=> irq_o);
  // R9
  en_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_reg |=> $stable(en_q));
endmodule

// File: tb/test_btn_port.sv
`timescale 1ns/1ps
module test_btn_port;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  btn_ni = 4'hF;
  logic        wr_en_i = 1'b0;
  logic [3:0]  addr_i = 4'h0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;
  int n_run = 0, n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  btn_port i_btn_port (
    .clk_i(clk_i), .rst_ni(rst_ni), .btn_ni(btn_ni), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i); addr_i = a; #0.5; d = rdata_o;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i); wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic settle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk_i);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(4'h0, d); chk("R1 live", d, 0);
    rd(4'h8, d); chk("R1 enable", d, 0);
    rd(4'hC, d); chk("R1 capture", d, 0);
    chk("R1 irq", {31'd0, irq_o}, 0);
  endtask

  task automatic t_live;
    logic [31:0] d;
    @(negedge clk_i); btn_ni = 4'b1010; addr_i = 4'h0;
    @(negedge clk_i); chk("R2 one edge", rdata_o, 0);
    @(negedge clk_i); chk("R2 two edges", rdata_o, 32'h5);
    rd(4'hC, d); chk("R4 press sets nothing", d, 0);
    @(negedge clk_i); btn_ni = 4'hF;
    settle(3);
    rd(4'h0, d); chk("R2 released", d, 0);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    wr(4'h8, 32'hFFFF_FFF6);
    rd(4'h8, d); chk("R3 readback", d, 32'h6);
    wr(4'h0, 32'hFFFF_FFFF);
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h8, d); chk("R9 stray write", d, 32'h6);
    rd(4'h4, d); chk("R9 unused read", d, 0);
    rd(4'hF, d); chk("R9 unused read F", d, 0);
  endtask

  task automatic t_capture_irq;
    logic [31:0] d;
    // buttons 0 and 2 were released in t_live
    rd(4'hC, d); chk("R4 release capture", d, 32'h5);
    chk("R8 irq from b2", {31'd0, irq_o}, 1);
    wr(4'hC, 32'h4);
    rd(4'hC, d); chk("R6 partial clear", d, 32'h1);
    chk("R8 masked b0 no irq", {31'd0, irq_o}, 0);
    @(negedge clk_i); btn_ni = 4'b1110;
    settle(4);
    rd(4'hC, d); chk("R5 sticky on re-press", d, 32'h1);
    @(negedge clk_i); btn_ni = 4'hF;
    settle(4);
    wr(4'h8, 32'h1);
    chk("R8 irq after enable", {31'd0, irq_o}, 1);
    wr(4'hC, 32'h1);
    rd(4'hC, d); chk("R6 clear b0", d, 0);
    chk("R8 irq dropped", {31'd0, irq_o}, 0);
  endtask

  task automatic t_priority;
    logic [31:0] d;
    @(negedge clk_i); btn_ni = 4'b0111;
    settle(4);
    @(negedge clk_i); btn_ni = 4'hF;
    settle(4);
    rd(4'hC, d); chk("R4 b3 capture", d, 32'h8);
    @(negedge clk_i); btn_ni = 4'b0111;
    settle(4);
    @(negedge clk_i); btn_ni = 4'hF;   // release seen at third edge
    @(negedge clk_i);
    @(negedge clk_i); wr_en_i = 1'b1; addr_i = 4'hC; wdata_i = 32'h8;
    @(negedge clk_i); wr_en_i = 1'b0; wdata_i = '0;
    rd(4'hC, d); chk("R7 set wins", d, 32'h8);
    wr(4'hC, 32'hF);
    rd(4'hC, d); chk("R6 clear all", d, 0);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    settle(3);
    rst_ni = 1'b1;
    t_reset();
    t_live();
    t_enable();
    t_capture_irq();
    t_priority();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule